// File: doc/BRIEF.md
# SD Card Clock Generator

This block produces the card clock for an SD host controller from a single fast reference clock, `clk_2x`. It runs at twice the multiplied base clock, so every phase of the output is a whole number of reference cycles. Software drives the generator through one 16-bit control word. The word holds an internal enable, a read-only "stable" flag, a card clock gate, a generator select bit and a 10-bit frequency code.

There are three ways of turning the frequency code into a card clock:
- **Divided mode** divides the base clock by an even number.
- **Programmable mode** divides the multiplied clock by code+1. It is available only when the capability multiplier input is nonzero.
- **Legacy mode** uses power-of-two divisors taken from the low byte of the code.

When preset override is enabled, the select bit and the frequency code follow a per-speed-mode preset table, and software cannot change them.

Every configuration change waits for a falling edge of the card clock, so no short pulse reaches the card.

Top module: `sd_card_clkgen`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` reads 0x0000 and `sdclk` is low.
- R2: Control word layout:
  - bit 0 is the internal enable and bit 2 is the card clock gate; both are written from `wr_data` when `wr_en` is high.
  - bit 1 is the stable flag and cannot be written.
  - bit 5 is the generator select.
  - bits 7:6 hold code bits 9:8 and bits 15:8 hold code bits 7:0.
  - bits 4:3 always read 0.
- R3: The stable flag reads 1 exactly STABLE_CYC cycles after the write that sets the internal enable. It reads 0 in the first cycle after the internal enable is cleared.
- R4: `sdclk` toggles only while both the card gate and the stable flag are 1; otherwise it is held low. Removing the gate never shortens a high phase that has already started.
- R5: In divided mode (select 0, legacy off), with M the effective multiplier, each half period of `sdclk` lasts M·2·code cycles of `clk_2x` for code ≥ 1, and M cycles for code 0.
- R6: In programmable mode (select 1, nonzero multiplier, legacy off), each half period lasts code+1 cycles of `clk_2x`, for any code from 0 to 1023.
- R7: The effective multiplier M is `cap_mul`+1 when `cap_mul` is nonzero, and 1 otherwise. While `cap_mul` is zero, the select bit reads 0 whatever is written, and the generator stays in divided mode.
- R8: With `legacy_en` high, a half period lasts M cycles when the low byte v of the code is 0. Otherwise it lasts M·2·2^k cycles, where k is the position of the highest set bit of v. The select bit and code bits 9:8 have no effect in this mode.
- R9: While `preset_en` is high, the select bit and the code are loaded each cycle from entry `speed_mode` of `preset_flat`. Entry i occupies bits [11i+10:11i]; bit 10 of the entry is the select and bits 9:0 are the code. Writes to the select bit and the code are ignored; bits 0 and 2 stay writable.
- R10: A new frequency setting takes effect at the next falling edge of `sdclk`. The high phase in progress completes with its old length, and the following low phase uses the new one.
- R11: Both phases of `sdclk` have equal length in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Reference clock, twice the multiplied base rate |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word write value |
| rd_data | output | 16 | Control word read value |
| cap_mul | input | MUL_W | Capability multiplier code (0 = no programmable mode) |
| legacy_en | input | 1 | Selects power-of-two legacy divisors |
| preset_en | input | 1 | Preset override enable |
| speed_mode | input | SPD_W | Selected bus speed mode, indexes the preset table |
| preset_flat | input | NUM_SPEED·11 | Packed preset table, one {select, code} entry per speed mode |
| sdclk | output | 1 | Card clock |

## Verification
The assertions assume the following:
- Reset is asserted from time zero.
- `cap_mul` and `legacy_en` are quasi-static controls that change only between clock edges, like every other input.
- `speed_mode` indexes an entry that exists in the preset table.

The bench changes all inputs at falling edges of `clk_2x`. It holds the multiplier, legacy and preset inputs steady while a period is measured, and it draws speed modes only from the table's range. Random trials keep codes small so that each measured period stays short, and directed trials cover codes 0, 1 and 1023.

// File: rtl/sdclk_pkg.sv
// Shared constants and types for the card clock generator.
// Assumes the control word layout is fixed at 16 bits with a 10-bit code.
package sdclk_pkg;
    localparam int REG_W = 16;
    localparam int DIV_W = 10;
    localparam int LEG_W = 8;
    localparam int PRE_W = DIV_W + 1;

    typedef enum logic [1:0] {
        GEN_DIVIDED = 2'd0,
        GEN_PROGRAM = 2'd1,
        GEN_LEGACY  = 2'd2
    } gen_mode_t;

    // Position of the highest set bit of a legacy divisor byte.
    function automatic logic [2:0] top_bit(input logic [LEG_W-1:0] v);
        top_bit = 3'd0;
        for (int i = 0; i < LEG_W; i++) begin
            if (v[i]) top_bit = 3'(i);
        end
    endfunction
endpackage

// File: rtl/sdclk_ctrl_reg.sv
// Control word storage, preset override and internal-clock stable timer.
// Assumes cap_mul is quasi-static; preset fields arrive already selected.
module sdclk_ctrl_reg
    import sdclk_pkg::*;
#(
    parameter int MUL_W      = 8,
    parameter int STABLE_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [MUL_W-1:0] cap_mul,
    input  logic             preset_en,
    input  logic             preset_sel,
    input  logic [DIV_W-1:0] preset_n,
    output logic             int_en,
    output logic             card_en,
    output logic             sel,
    output logic [DIV_W-1:0] n_code,
    output logic             stable,
    output logic [REG_W-1:0] rd_data
);
    localparam int SCNT_W = $clog2(STABLE_CYC + 1);

    logic             int_en_q, card_en_q, sel_q;
    logic [DIV_W-1:0] n_q;
    logic [SCNT_W-1:0] scnt_q;
    logic             prog_ok;

    assign prog_ok = |cap_mul;

    // Field registers: enables from writes, select and code from preset or writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_en_q  <= 1'b0;
            card_en_q <= 1'b0;
            sel_q     <= 1'b0;
            n_q       <= '0;
        end else begin
            if (wr_en) begin
                int_en_q  <= wr_data[0];
                card_en_q <= wr_data[2];
            end
            if (preset_en) begin
                sel_q <= preset_sel & prog_ok;
                n_q   <= preset_n;
            end else if (wr_en) begin
                sel_q <= wr_data[5] & prog_ok;
                n_q   <= {wr_data[7:6], wr_data[15:8]};
            end else if (!prog_ok) begin
                sel_q <= 1'b0;
            end
        end
    end

    // Stable timer: counts up after enable, saturates, clears when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !int_en_q) begin
            scnt_q <= '0;
        end else if (scnt_q != SCNT_W'(STABLE_CYC)) begin
            scnt_q <= scnt_q + SCNT_W'(1);
        end
    end

    assign stable  = int_en_q && (scnt_q == SCNT_W'(STABLE_CYC));
    assign int_en  = int_en_q;
    assign card_en = card_en_q;
    assign sel     = sel_q;
    assign n_code  = n_q;
    assign rd_data = {n_q[7:0], n_q[9:8], sel_q, 2'b00, card_en_q, stable, int_en_q};

    p_stable_after_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable) |-> ($past(int_en_q) && int_en_q));
    p_sel_needs_mult_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mul == '0) |=> !sel_q);
    p_preset_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        preset_en |=> (n_q == $past(preset_n)) && (sel_q == ($past(preset_sel) && $past(prog_ok))));
    p_gate_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (card_en_q == $past(wr_data[2])) && (int_en_q == $past(wr_data[0])));
endmodule

// File: rtl/sdclk_div_calc.sv
// Converts mode, multiplier and code into a half-period length in reference cycles.
// Purely combinational; result is always at least 1.
module sdclk_div_calc
    import sdclk_pkg::*;
#(
    parameter int MUL_W  = 8,
    parameter int HALF_W = MUL_W + DIV_W + 2
) (
    input  logic [MUL_W-1:0]  cap_mul,
    input  logic              legacy_en,
    input  logic              sel,
    input  logic [DIV_W-1:0]  n_code,
    output logic [HALF_W-1:0] half
);
    gen_mode_t         mode;
    logic [MUL_W:0]    mult;
    logic [HALF_W-1:0] mult_w;
    logic [LEG_W-1:0]  leg_v;

    // Effective multiplier: code+1, or unity when the capability is absent.
    always_comb begin
        mult   = (cap_mul == '0) ? (MUL_W+1)'(1) : ({1'b0, cap_mul} + (MUL_W+1)'(1));
        mult_w = HALF_W'(mult);
        leg_v  = n_code[LEG_W-1:0];
    end

    // Mode decode: legacy wins, then programmable select.
    always_comb begin
        if (legacy_en)  mode = GEN_LEGACY;
        else if (sel)   mode = GEN_PROGRAM;
        else            mode = GEN_DIVIDED;
    end

    // Half-period selection per mode.
    always_comb begin
        unique case (mode)
            GEN_LEGACY:  half = (leg_v == '0) ? mult_w
                                : (mult_w << (4'(top_bit(leg_v)) + 4'd1));
            GEN_PROGRAM: half = HALF_W'(n_code) + HALF_W'(1);
            default:     half = (n_code == '0) ? mult_w
                                : (mult_w * HALF_W'({n_code, 1'b0}));
        endcase
    end
endmodule

// File: rtl/sdclk_phase_gen.sv
// Generates the card clock from a half-period length; loads new lengths only
// at a falling edge and parks low when not running.
// Assumes half_new is never zero.
module sdclk_phase_gen #(
    parameter int HALF_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_new,
    output logic              sdclk
);
    logic              out_q;
    logic [HALF_W-1:0] cnt_q, half_act;

    // Phase counter: finishes a high phase, then reloads or parks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q    <= 1'b0;
            cnt_q    <= '0;
            half_act <= HALF_W'(1);
        end else if (out_q) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - HALF_W'(1);
            end else begin
                out_q    <= 1'b0;
                half_act <= half_new;
                cnt_q    <= half_new - HALF_W'(1);
            end
        end else if (!run) begin
            cnt_q    <= '0;
            half_act <= half_new;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - HALF_W'(1);
        end else begin
            out_q <= 1'b1;
            cnt_q <= half_act - HALF_W'(1);
        end
    end

    assign sdclk = out_q;

    p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !out_q) |=> !out_q);
    p_high_not_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q && cnt_q != '0) |=> out_q);
    p_fall_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_q) |-> (half_act == $past(half_new)));
endmodule

// File: rtl/sd_card_clkgen.sv
// Top of the card clock generator: control word, preset table select,
// half-period calculation and glitch-free phase generation.
// Assumes clk_2x runs at twice the multiplied base clock.
module sd_card_clkgen
    import sdclk_pkg::*;
#(
    parameter int MUL_W      = 8,
    parameter int STABLE_CYC = 8,
    parameter int NUM_SPEED  = 5,
    localparam int SPD_W     = $clog2(NUM_SPEED),
    localparam int HALF_W    = MUL_W + DIV_W + 2
) (
    input  logic                     clk_2x,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [REG_W-1:0]         wr_data,
    output logic [REG_W-1:0]         rd_data,
    input  logic [MUL_W-1:0]         cap_mul,
    input  logic                     legacy_en,
    input  logic                     preset_en,
    input  logic [SPD_W-1:0]         speed_mode,
    input  logic [NUM_SPEED*PRE_W-1:0] preset_flat,
    output logic                     sdclk
);
    logic [PRE_W-1:0]  preset_tab [NUM_SPEED];
    logic [PRE_W-1:0]  preset_cur;
    logic              int_en, card_en, sel, stable;
    logic [DIV_W-1:0]  n_code;
    logic [HALF_W-1:0] half;

    for (genvar g = 0; g < NUM_SPEED; g++) begin : g_preset
        assign preset_tab[g] = preset_flat[g*PRE_W +: PRE_W];
    end

    // Preset entry for the current speed mode, entry 0 when out of range.
    always_comb begin
        preset_cur = (int'(speed_mode) < NUM_SPEED) ? preset_tab[speed_mode] : preset_tab[0];
    end

    sdclk_ctrl_reg #(.MUL_W(MUL_W), .STABLE_CYC(STABLE_CYC)) u_reg (
        .clk        (clk_2x),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cap_mul    (cap_mul),
        .preset_en  (preset_en),
        .preset_sel (preset_cur[DIV_W]),
        .preset_n   (preset_cur[DIV_W-1:0]),
        .int_en     (int_en),
        .card_en    (card_en),
        .sel        (sel),
        .n_code     (n_code),
        .stable     (stable),
        .rd_data    (rd_data)
    );

    sdclk_div_calc #(.MUL_W(MUL_W), .HALF_W(HALF_W)) u_calc (
        .cap_mul   (cap_mul),
        .legacy_en (legacy_en),
        .sel       (sel),
        .n_code    (n_code),
        .half      (half)
    );

    sdclk_phase_gen #(.HALF_W(HALF_W)) u_phase (
        .clk      (clk_2x),
        .rst_n    (rst_n),
        .run      (card_en && stable),
        .half_new (half),
        .sdclk    (sdclk)
    );

    p_run_needs_enable_r4: assert property (@(posedge clk_2x) disable iff (!rst_n)
        $rose(sdclk) |-> (int_en && card_en));
endmodule

// File: tb/sim_sd_card_clkgen.sv
module sim_sd_card_clkgen;
    localparam int STABLE = 8;
    localparam int NSP    = 5;
    localparam int LIM    = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [7:0]  cap_mul = '0;
    logic        legacy_en = 1'b0;
    logic        preset_en = 1'b0;
    logic [2:0]  speed_mode = '0;
    logic [NSP*11-1:0] preset_flat = '0;
    logic        sdclk;
    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    sd_card_clkgen u0 (
        .clk_2x(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cap_mul(cap_mul), .legacy_en(legacy_en),
        .preset_en(preset_en), .speed_mode(speed_mode),
        .preset_flat(preset_flat), .sdclk(sdclk)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] regval(input logic ie, input logic ce, input logic s, input logic [9:0] n);
        return {n[7:0], n[9:8], s, 2'b00, ce, 1'b0, ie};
    endfunction

    function automatic longint exp_half(input int cap, input bit leg, input bit s, input int n);
        longint m = (cap == 0) ? 1 : cap + 1;
        if (leg) begin
            int v = n & 255;
            longint p = 1;
            if (v == 0) return m;
            for (int i = 0; i < 8; i++) if (v[i]) p = 2 << i;
            return m * p;
        end
        if (s && cap != 0) return n + 1;
        if (n == 0) return m;
        return m * 2 * n;
    endfunction

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_level(input logic v);
        int k = 0;
        @(negedge clk);
        while (sdclk !== v && k < LIM) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic measure(output longint h, output longint l);
        wait_level(1'b1);
        wait_level(1'b0);
        wait_level(1'b1);
        h = 0;
        while (sdclk === 1'b1 && h < LIM) begin h++; @(negedge clk); end
        l = 0;
        while (sdclk === 1'b0 && l < LIM) begin l++; @(negedge clk); end
    endtask

    task automatic run_cfg(input string req, input int cap, input bit leg, input bit s, input int n);
        longint h, l, e;
        cap_mul = 8'(cap);
        legacy_en = leg;
        wr(regval(1'b1, 1'b1, s, 10'(n)));
        measure(h, l);
        e = exp_half(cap, leg, s, n);
        check(req, $sformatf("high cap=%0d leg=%0d sel=%0d n=%0d", cap, leg, s, n), h, e);
        check(req, $sformatf("low cap=%0d leg=%0d sel=%0d n=%0d", cap, leg, s, n), l, e);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        longint h, l;
        int k;
        int unsigned seed;
        seed = $urandom(32'd20240);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "rd_data after reset", rd_data, 0);
        k = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (sdclk) k++; end
        check("R1", "sdclk high samples after reset", k, 0);

        // R2 layout: stable not writable, bits 4:3 zero
        cap_mul = 8'd1;
        wr(16'hFFFF);
        check("R2", "readback of all-ones write", rd_data, 16'hFFE5);
        wr(16'h0000);
        check("R2", "readback of zero write", rd_data, 0);

        // R3 stable timing
        wr(16'h0001);
        k = 0;
        while (rd_data[1] == 1'b0 && k < 100) begin @(negedge clk); k++; end
        check("R3", "cycles to stable", k, STABLE);
        wr(16'h0000);
        check("R3", "stable right after disable", rd_data[1], 0);

        // R5 divided mode
        run_cfg("R5", 0, 1'b0, 1'b0, 0);
        run_cfg("R5", 0, 1'b0, 1'b0, 1);
        run_cfg("R5", 3, 1'b0, 1'b0, 0);
        run_cfg("R5", 1, 1'b0, 1'b0, 1023);
        // R6 programmable mode, boundary codes
        run_cfg("R6", 1, 1'b0, 1'b1, 0);
        run_cfg("R6", 1, 1'b0, 1'b1, 1);
        run_cfg("R6", 5, 1'b0, 1'b1, 1023);
        // R7 no multiplier: select forced to 0, divided used
        run_cfg("R7", 0, 1'b0, 1'b1, 3);
        check("R7", "select bit with cap 0", rd_data[5], 0);
        // R8 legacy mode, select and high code bits ignored
        run_cfg("R8", 1, 1'b1, 1'b1, 10'h30C);
        run_cfg("R8", 0, 1'b1, 1'b0, 8);
        run_cfg("R8", 0, 1'b1, 1'b0, 0);
        legacy_en = 1'b0;

        // R10 change during a high phase
        run_cfg("R10", 1, 1'b0, 1'b1, 19);
        wait_level(1'b0);
        wait_level(1'b1);
        wr_en = 1'b1;
        wr_data = regval(1'b1, 1'b1, 1'b1, 10'd3);
        h = 1;
        @(negedge clk);
        wr_en = 1'b0;
        while (sdclk === 1'b1 && h < LIM) begin h++; @(negedge clk); end
        l = 0;
        while (sdclk === 1'b0 && l < LIM) begin l++; @(negedge clk); end
        check("R10", "high phase kept old length", h, 20);
        check("R10", "low phase uses new length", l, 4);

        // R4 gate removed mid-high: high completes, then held low
        run_cfg("R4", 1, 1'b0, 1'b1, 19);
        wait_level(1'b0);
        wait_level(1'b1);
        wr_en = 1'b1;
        wr_data = regval(1'b1, 1'b0, 1'b1, 10'd19);
        h = 1;
        @(negedge clk);
        wr_en = 1'b0;
        while (sdclk === 1'b1 && h < LIM) begin h++; @(negedge clk); end
        check("R4", "high phase not cut by gate", h, 20);
        k = 0;
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (sdclk) k++; end
        check("R4", "high samples while gated", k, 0);

        // R9 preset override
        preset_flat[2*11 +: 11] = {1'b1, 10'd5};
        preset_flat[3*11 +: 11] = {1'b0, 10'd2};
        cap_mul = 8'd1;
        speed_mode = 3'd2;
        preset_en = 1'b1;
        wr(regval(1'b1, 1'b1, 1'b0, 10'd100));
        check("R9", "preset fields with write ignored", rd_data & 16'hFFFD, regval(1'b1, 1'b1, 1'b1, 10'd5));
        measure(h, l);
        check("R9", "preset entry 2 half", h, 6);
        check("R11", "preset entry 2 low equals high", l, h);
        speed_mode = 3'd3;
        measure(h, l);
        check("R9", "preset entry 3 half", h, 8);
        preset_en = 1'b0;

        // R11 random trials
        for (int t = 0; t < 12; t++) begin
            int cap = int'($urandom % 4);
            bit leg = ($urandom % 4) == 0;
            bit s = $urandom % 2;
            int n = leg ? int'($urandom % 256) : int'($urandom % 64);
            run_cfg("R11", cap, leg, s, n);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule